// File: doc/BRIEF.md
# Dual-Plane Voltage-ID Mode Controller

This block is the digital supervisor of a two-plane processor regulator. It holds an 8-bit voltage-ID code for a core plane and one for an auxiliary plane. On the rising edge of its enable input it samples a strap pin to pick serial or parallel operation. In the same cycle it latches a 2-bit selector from two code pins. From then on it follows the power-good handshake and the commands that an upstream serial decoder has already decoded.

In serial operation both planes start at a boot code. Commands are accepted only once power-good has risen. If power-good later drops, both planes fall back to stored codes. If power-good is already high when enable rises, the block enters a fixed-voltage mode whose codes track the two code pins. In parallel operation a 6-bit bus sets the core plane, and the auxiliary plane is switched off and flagged for high impedance.

Output codes never jump after start-up. Each one moves one LSB per prescaler tick toward its target. An overvoltage-mask flag is raised while any plane is moving down. A ready output combines the enabled state with per-plane window reports.

Top module: `vid_plane_ctrl`

## Requirements
- R1: On the clock edge where `en_i` is first seen high, `strap_i` = 0 selects serial operation and `strap_i` = 1 selects parallel operation; `par_mode_o` is 1 only in parallel operation.
- R2: In serial operation with `pgood_i` low at enable, both codes equal 8'h40 + 8*idx right after the enable edge, where idx = {`sc_i`,`sd_i`}, and both planes are on.
- R3: Before `pgood_i` has been seen high, commands have no effect on either code.
- R4: When `pgood_i` falls after it has been high in serial operation, both targets become 8'h20 + 8*idx, using the idx latched at enable. Later commands are ignored until enable drops.
- R5: If `pgood_i` is high at the enable edge, fixed-voltage mode starts. Both codes equal 8'h60 + 8*idx at once, follow live changes of {`sc_i`,`sd_i`}, and commands are ignored.
- R6: In parallel operation the core target is {2'b00,`pvid_i`}. The auxiliary plane is off, `aux_hiz_o` is 1, its code stays 0, and commands are ignored.
- R7: Command op 1 turns a plane on and op 2 turns it off (`cmd_plane_i` 0 = core, 1 = aux). Op 0 sets the plane's target to `cmd_code_i`. An off plane keeps its code, and it moves to its target again once it is turned back on.
- R8: Command op 3 drives `psi_n_o` to `cmd_code_i[0]`. `psi_n_o` is 1 whenever enable is low.
- R9: `ovp_mask_o` is 1 exactly while some on plane's code is above its target. A code never decreases unless the mask was high in the cycle before.
- R10: `ready_o` is 1 when the block is enabled and every plane that is on reports in-window on `win_ok_i` (bit 0 core, bit 1 aux). Otherwise it is 0.
- R11: After start-up a code changes by at most one LSB per tick, with a tick every `rate_i`+1 cycles. An n-step move ends between 1+(n-1)(`rate_i`+1) and n(`rate_i`+1) cycles after the command edge.
- R12: One cycle after `en_i` goes low, both codes are 0, both planes are off, and `ready_o`, `par_mode_o`, `aux_hiz_o` and `ovp_mask_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| strap_i | input | 1 | Mode strap, sampled at enable |
| sc_i | input | 1 | Code selector bit 1 |
| sd_i | input | 1 | Code selector bit 0 |
| pgood_i | input | 1 | Power-good from the system |
| pvid_i | input | 6 | Parallel voltage-ID bus |
| rate_i | input | 8 | Prescaler limit; a tick every rate_i+1 cycles |
| cmd_valid_i | input | 1 | Decoded command strobe |
| cmd_op_i | input | 2 | 0 set code, 1 on, 2 off, 3 power-save |
| cmd_plane_i | input | 1 | Command plane: 0 core, 1 aux |
| cmd_code_i | input | 8 | Command code or power-save level in bit 0 |
| win_ok_i | input | 2 | Per-plane in-window report |
| core_code_o | output | 8 | Core plane output code |
| aux_code_o | output | 8 | Auxiliary plane output code |
| core_on_o | output | 1 | Core plane enabled |
| aux_on_o | output | 1 | Auxiliary plane enabled |
| aux_hiz_o | output | 1 | Auxiliary power stage high-impedance request |
| par_mode_o | output | 1 | Parallel operation active |
| psi_n_o | output | 1 | Power-save level for core phase controllers |
| ovp_mask_o | output | 1 | Overvoltage mask during downward moves |
| ready_o | output | 1 | Regulator ready |

## Verification
The hardest state to reach is the fallback to stored codes. It needs a serial enable with power-good low, then power-good rising into the command phase, and then power-good dropping while enable stays high. Only then can the bench see that the fallback codes come from the selector latched at enable and not from the live pins. The bench walks that full sequence for every selector value and changes the pins after enable, so that a design reading the live pins gives a different code. It also sweeps all 64 parallel codes in a scrambled order, so that long moves in both directions are exercised.

// File: rtl/vidc_pkg.sv
package vidc_pkg;
   localparam int NPLANE   = 2;
   localparam int PL_CORE  = 0;
   localparam int PL_AUX   = 1;
   localparam int SEL_W    = 2;
   localparam int NSEL     = 1 << SEL_W;

   typedef enum logic [2:0] {
      VS_OFF  = 3'd0,
      VS_BOOT = 3'd1,
      VS_LIVE = 3'd2,
      VS_FALL = 3'd3,
      VS_FIX  = 3'd4,
      VS_PAR  = 3'd5
   } vidc_st_e;

   typedef enum logic [1:0] {
      OP_SET = 2'd0,
      OP_ON  = 2'd1,
      OP_OFF = 2'd2,
      OP_PSI = 2'd3
   } vidc_op_e;
endpackage

// File: rtl/vidc_tick.sv
module vidc_tick #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              tick_o
);
   logic [RATE_W-1:0] cnt_q;

   assign tick_o = en_i && (cnt_q == rate_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/vidc_seq.sv
module vidc_seq
   import vidc_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int PVID_W = 6,
   parameter logic [NSEL-1:0][CODE_W-1:0] BOOT_TAB = '0,
   parameter logic [NSEL-1:0][CODE_W-1:0] PRE_TAB  = '0,
   parameter logic [NSEL-1:0][CODE_W-1:0] FIX_TAB  = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en_i,
   input  logic                          strap_i,
   input  logic [SEL_W-1:0]              sel_i,
   input  logic                          pgood_i,
   input  logic [PVID_W-1:0]             pvid_i,
   input  logic                          cmd_valid_i,
   input  logic [1:0]                    cmd_op_i,
   input  logic                          cmd_plane_i,
   input  logic [CODE_W-1:0]             cmd_code_i,
   output vidc_st_e                      st_o,
   output logic                          init_o,
   output logic [NPLANE-1:0][CODE_W-1:0] init_val_o,
   output logic [NPLANE-1:0][CODE_W-1:0] tgt_o,
   output logic [NPLANE-1:0]             on_o,
   output logic                          psi_n_o
);
   localparam int PAD_W = CODE_W - PVID_W;

   vidc_st_e                      st_q;
   logic                          en_q;
   logic [SEL_W-1:0]              sel_q;
   logic [NPLANE-1:0][CODE_W-1:0] tgt_q;
   logic [NPLANE-1:0]             on_q;
   logic                          psi_q;
   logic [CODE_W-1:0]             pvid_ext;
   vidc_op_e                      op;

   assign pvid_ext = {{PAD_W{1'b0}}, pvid_i};
   assign op       = vidc_op_e'(cmd_op_i);
   assign init_o   = en_i && !en_q;

   // Start-up codes, chosen from the pins at the enable edge
   always_comb begin
      init_val_o = '0;
      if (strap_i) begin
         init_val_o[PL_CORE] = pvid_ext;
      end else begin
         for (int p = 0; p < NPLANE; p++) begin
            init_val_o[p] = pgood_i ? FIX_TAB[sel_i] : BOOT_TAB[sel_i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= en_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= VS_OFF;
         sel_q <= '0;
         tgt_q <= '0;
         on_q  <= '0;
         psi_q <= 1'b1;
      end else if (!en_i) begin
         st_q  <= VS_OFF;
         sel_q <= '0;
         tgt_q <= '0;
         on_q  <= '0;
         psi_q <= 1'b1;
      end else if (init_o) begin
         sel_q <= sel_i;
         tgt_q <= init_val_o;
         psi_q <= 1'b1;
         if (strap_i) begin
            st_q          <= VS_PAR;
            on_q          <= '0;
            on_q[PL_CORE] <= 1'b1;
         end else begin
            st_q <= pgood_i ? VS_FIX : VS_BOOT;
            on_q <= '1;
         end
      end else begin
         unique case (st_q)
            VS_BOOT: begin
               if (pgood_i) st_q <= VS_LIVE;
            end
            VS_LIVE: begin
               if (!pgood_i) begin
                  st_q <= VS_FALL;
                  for (int p = 0; p < NPLANE; p++) tgt_q[p] <= PRE_TAB[sel_q];
               end else if (cmd_valid_i) begin
                  unique case (op)
                     OP_SET: tgt_q[cmd_plane_i] <= cmd_code_i;
                     OP_ON:  on_q[cmd_plane_i]  <= 1'b1;
                     OP_OFF: on_q[cmd_plane_i]  <= 1'b0;
                     OP_PSI: psi_q              <= cmd_code_i[0];
                     default: ;
                  endcase
               end
            end
            VS_FIX: begin
               for (int p = 0; p < NPLANE; p++) tgt_q[p] <= FIX_TAB[sel_i];
            end
            VS_PAR: begin
               tgt_q[PL_CORE] <= pvid_ext;
            end
            default: ;
         endcase
      end
   end

   assign st_o    = st_q;
   assign tgt_o   = tgt_q;
   assign on_o    = on_q;
   assign psi_n_o = psi_q;
endmodule

// File: rtl/vidc_ramp.sv
module vidc_ramp #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              init_i,
   input  logic [CODE_W-1:0] init_val_i,
   input  logic              tick_i,
   input  logic              on_i,
   input  logic [CODE_W-1:0] tgt_i,
   output logic [CODE_W-1:0] code_o,
   output logic              down_o
);
   logic [CODE_W-1:0] code_q;
   logic              up, dn;

   assign up     = on_i && (code_q < tgt_i);
   assign dn     = on_i && (code_q > tgt_i);
   assign down_o = dn;
   assign code_o = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (!en_i) begin
         code_q <= '0;
      end else if (init_i) begin
         code_q <= init_val_i;
      end else if (tick_i && up) begin
         code_q <= code_q + 1'b1;
      end else if (tick_i && dn) begin
         code_q <= code_q - 1'b1;
      end
   end
endmodule

// File: rtl/vid_plane_ctrl.sv
module vid_plane_ctrl
   import vidc_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int PVID_W = 6,
   parameter int RATE_W = 8,
   parameter logic [NSEL-1:0][CODE_W-1:0] BOOT_TAB = {8'h58, 8'h50, 8'h48, 8'h40},
   parameter logic [NSEL-1:0][CODE_W-1:0] PRE_TAB  = {8'h38, 8'h30, 8'h28, 8'h20},
   parameter logic [NSEL-1:0][CODE_W-1:0] FIX_TAB  = {8'h78, 8'h70, 8'h68, 8'h60}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              strap_i,
   input  logic              sc_i,
   input  logic              sd_i,
   input  logic              pgood_i,
   input  logic [PVID_W-1:0] pvid_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic              cmd_plane_i,
   input  logic [CODE_W-1:0] cmd_code_i,
   input  logic [1:0]        win_ok_i,
   output logic [CODE_W-1:0] core_code_o,
   output logic [CODE_W-1:0] aux_code_o,
   output logic              core_on_o,
   output logic              aux_on_o,
   output logic              aux_hiz_o,
   output logic              par_mode_o,
   output logic              psi_n_o,
   output logic              ovp_mask_o,
   output logic              ready_o
);
   if (CODE_W <= PVID_W) begin : g_bad_code_w
      $error("CODE_W must exceed PVID_W");
   end
   if (RATE_W < 1) begin : g_bad_rate_w
      $error("RATE_W must be at least 1");
   end

   vidc_st_e                      st;
   logic                          init;
   logic [NPLANE-1:0][CODE_W-1:0] init_val;
   logic [NPLANE-1:0][CODE_W-1:0] tgt;
   logic [NPLANE-1:0][CODE_W-1:0] code;
   logic [NPLANE-1:0]             on;
   logic [NPLANE-1:0]             down;
   logic [NPLANE-1:0]             plane_ok;
   logic                          tick;

   vidc_tick #(.RATE_W(RATE_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .rate_i (rate_i),
      .tick_o (tick)
   );

   vidc_seq #(
      .CODE_W   (CODE_W),
      .PVID_W   (PVID_W),
      .BOOT_TAB (BOOT_TAB),
      .PRE_TAB  (PRE_TAB),
      .FIX_TAB  (FIX_TAB)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .strap_i     (strap_i),
      .sel_i       ({sc_i, sd_i}),
      .pgood_i     (pgood_i),
      .pvid_i      (pvid_i),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .cmd_plane_i (cmd_plane_i),
      .cmd_code_i  (cmd_code_i),
      .st_o        (st),
      .init_o      (init),
      .init_val_o  (init_val),
      .tgt_o       (tgt),
      .on_o        (on),
      .psi_n_o     (psi_n_o)
   );

   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      vidc_ramp #(.CODE_W(CODE_W)) u_ramp (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_i       (en_i),
         .init_i     (init),
         .init_val_i (init_val[p]),
         .tick_i     (tick),
         .on_i       (on[p]),
         .tgt_i      (tgt[p]),
         .code_o     (code[p]),
         .down_o     (down[p])
      );
      assign plane_ok[p] = !on[p] || win_ok_i[p];
   end

   assign core_code_o = code[PL_CORE];
   assign aux_code_o  = code[PL_AUX];
   assign core_on_o   = on[PL_CORE];
   assign aux_on_o    = on[PL_AUX];
   assign par_mode_o  = (st == VS_PAR);
   assign aux_hiz_o   = (st == VS_PAR);
   assign ovp_mask_o  = |down;
   assign ready_o     = (st != VS_OFF) && (&plane_ok);
endmodule

// File: rtl/vidc_chk.sv
module vidc_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic [1:0]        win_ok_i,
   input logic [CODE_W-1:0] core_code_o,
   input logic [CODE_W-1:0] aux_code_o,
   input logic              core_on_o,
   input logic              aux_on_o,
   input logic              aux_hiz_o,
   input logic              par_mode_o,
   input logic              psi_n_o,
   input logic              ovp_mask_o,
   input logic              ready_o
);
   a_r6_par_aux_off: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode_o |-> (aux_hiz_o && !aux_on_o));

   a_r11_core_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && $past(en_i, 2)) |->
         ((core_code_o == $past(core_code_o)) ||
          (core_code_o == $past(core_code_o) + 8'd1) ||
          (core_code_o == $past(core_code_o) - 8'd1)));

   a_r11_aux_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && $past(en_i, 2)) |->
         ((aux_code_o == $past(aux_code_o)) ||
          (aux_code_o == $past(aux_code_o) + 8'd1) ||
          (aux_code_o == $past(aux_code_o) - 8'd1)));

   a_r9_down_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && $past(en_i, 2) &&
       ((core_code_o < $past(core_code_o)) || (aux_code_o < $past(aux_code_o))))
         |-> $past(ovp_mask_o));

   a_r12_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> (core_code_o == '0 && aux_code_o == '0 && !core_on_o &&
                        !aux_on_o && !ready_o && !par_mode_o && !ovp_mask_o));

   a_r8_psi_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> psi_n_o);

   a_r10_core_window: assert property (@(posedge clk) disable iff (!rst_n)
      (core_on_o && !win_ok_i[0]) |-> !ready_o);

   a_r10_aux_window: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_on_o && !win_ok_i[1]) |-> !ready_o);
endmodule

bind vid_plane_ctrl vidc_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/vid_plane_ctrl_bench.sv
module vid_plane_ctrl_bench;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0, strap_i = 1'b0, sc_i = 1'b0, sd_i = 1'b0, pgood_i = 1'b0;
   logic [5:0] pvid_i = '0;
   logic [7:0] rate_i = 8'd2;
   logic       cmd_valid_i = 1'b0;
   logic [1:0] cmd_op_i = '0;
   logic       cmd_plane_i = 1'b0;
   logic [7:0] cmd_code_i = '0;
   logic [1:0] win_ok_i = 2'b11;
   logic [7:0] core_code_o, aux_code_o;
   logic       core_on_o, aux_on_o, aux_hiz_o, par_mode_o, psi_n_o, ovp_mask_o, ready_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   vid_plane_ctrl u_vid_plane_ctrl (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int boot_v(int i); return 8'h40 + 8*i; endfunction
   function automatic int pre_v(int i);  return 8'h20 + 8*i; endfunction
   function automatic int fix_v(int i);  return 8'h60 + 8*i; endfunction

   task automatic enable(input bit strap, input int idx, input bit pg);
      strap_i = strap; sc_i = idx[1]; sd_i = idx[0]; pgood_i = pg; en_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic disable_all();
      en_i = 1'b0; pgood_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic send(input int op, input bit plane, input int code);
      cmd_valid_i = 1'b1; cmd_op_i = op[1:0]; cmd_plane_i = plane; cmd_code_i = code[7:0];
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic settle(input bit plane, input int exp, output int c);
      c = 0;
      while (((plane ? aux_code_o : core_code_o) != exp[7:0]) && c < 3000) begin
         @(negedge clk);
         c++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int c;
      int sv;
      @(negedge clk);
      @(negedge clk);
      // R12: reset state
      check(core_code_o == 0 && aux_code_o == 0, "R12 reset codes", core_code_o, 0);
      check(!ready_o && !core_on_o && !aux_on_o && psi_n_o, "R12 reset flags", ready_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int idx = 0; idx < 4; idx++) begin
         // R1, R2: serial boot at enable
         enable(1'b0, idx, 1'b0);
         check(core_code_o == boot_v(idx), "R2 core boot", core_code_o, boot_v(idx));
         check(aux_code_o == boot_v(idx), "R2 aux boot", aux_code_o, boot_v(idx));
         check(core_on_o && aux_on_o && !par_mode_o && !aux_hiz_o, "R1 serial mode", par_mode_o, 0);
         // change pins after enable so fallback must use the latched idx
         sc_i = ~sc_i; sd_i = ~sd_i;
         // R3: command before power-good has no effect
         send(0, 1'b0, 8'h10);
         repeat (12) @(negedge clk);
         check(core_code_o == boot_v(idx), "R3 pre-pgood ignored", core_code_o, boot_v(idx));
         pgood_i = 1'b1;
         @(negedge clk);
         // R11: upward move of 5 steps with rate 2
         send(0, 1'b0, boot_v(idx) + 5);
         settle(1'b0, boot_v(idx) + 5, c);
         check(c >= 13 && c <= 15, "R11 slew timing", c, 14);
         // R7: aux off holds its code
         send(2, 1'b1, 0);
         check(!aux_on_o, "R7 aux off", aux_on_o, 0);
         win_ok_i = 2'b01;
         @(negedge clk);
         check(ready_o, "R10 off plane not counted", ready_o, 1);
         send(0, 1'b1, 8'h10);
         repeat (20) @(negedge clk);
         check(aux_code_o == boot_v(idx), "R7 off plane holds", aux_code_o, boot_v(idx));
         send(1, 1'b1, 0);
         check(aux_on_o && ovp_mask_o, "R9 mask on downward", ovp_mask_o, 1);
         check(!ready_o, "R10 aux out of window", ready_o, 0);
         win_ok_i = 2'b11;
         settle(1'b1, 8'h10, c);
         check(aux_code_o == 8'h10, "R7 aux reaches target", aux_code_o, 8'h10);
         check(!ovp_mask_o && ready_o, "R9 mask clear when settled", ovp_mask_o, 0);
         win_ok_i = 2'b10;
         #1;
         check(!ready_o, "R10 core out of window", ready_o, 0);
         win_ok_i = 2'b11;
         // R8: power-save level
         send(3, 1'b0, 0);
         check(!psi_n_o, "R8 psi low", psi_n_o, 0);
         send(3, 1'b0, 1);
         check(psi_n_o, "R8 psi high", psi_n_o, 1);
         // R4: fallback
         pgood_i = 1'b0;
         @(negedge clk);
         check(ovp_mask_o, "R9 mask on fallback", ovp_mask_o, 1);
         settle(1'b0, pre_v(idx), c);
         check(core_code_o == pre_v(idx), "R4 core fallback", core_code_o, pre_v(idx));
         settle(1'b1, pre_v(idx), c);
         check(aux_code_o == pre_v(idx), "R4 aux fallback", aux_code_o, pre_v(idx));
         send(0, 1'b0, 8'h70);
         repeat (12) @(negedge clk);
         check(core_code_o == pre_v(idx), "R4 commands ignored", core_code_o, pre_v(idx));
         disable_all();
         check(core_code_o == 0 && aux_code_o == 0 && !ready_o && psi_n_o, "R12 cleared", core_code_o, 0);
         @(negedge clk);
      end

      // R5: fixed-voltage mode
      for (int idx = 0; idx < 4; idx++) begin
         enable(1'b0, idx, 1'b1);
         check(core_code_o == fix_v(idx) && aux_code_o == fix_v(idx), "R5 fixed start", core_code_o, fix_v(idx));
         sc_i = ~idx[1]; sd_i = ~idx[0];
         settle(1'b1, fix_v(3 - idx), c);
         check(aux_code_o == fix_v(3 - idx) && core_code_o == fix_v(3 - idx), "R5 fixed follows pins", aux_code_o, fix_v(3 - idx));
         send(0, 1'b0, 8'h05);
         repeat (12) @(negedge clk);
         check(core_code_o == fix_v(3 - idx), "R5 commands ignored", core_code_o, fix_v(3 - idx));
         disable_all();
         @(negedge clk);
      end

      // R6: parallel sweep over all 64 codes, fastest rate
      rate_i = 8'd0;
      pvid_i = 6'd9;
      enable(1'b1, 0, 1'b0);
      check(par_mode_o && aux_hiz_o && !aux_on_o && core_on_o, "R1 parallel mode", par_mode_o, 1);
      check(core_code_o == 9, "R6 parallel start", core_code_o, 9);
      win_ok_i = 2'b01;
      #1;
      check(ready_o, "R10 parallel ready", ready_o, 1);
      win_ok_i = 2'b11;
      for (int k = 0; k < 64; k++) begin
         sv = (k * 37 + 5) % 64;
         pvid_i = sv[5:0];
         settle(1'b0, sv, c);
         check(core_code_o == sv && c <= 66, "R6 parallel target", core_code_o, sv);
      end
      send(3, 1'b0, 0);
      send(0, 1'b1, 8'h30);
      send(1, 1'b1, 0);
      repeat (4) @(negedge clk);
      check(psi_n_o && aux_code_o == 0 && !aux_on_o, "R6 commands ignored", aux_code_o, 0);
      disable_all();
      check(!par_mode_o && !aux_hiz_o && core_code_o == 0, "R12 parallel cleared", core_code_o, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule